// File: doc/BRIEF.md
# Compare Flags and Condition Evaluator

This unit performs a non-destructive compare of two operands: it subtracts the second operand from the first at a selected width (8, 16 or 32 bits), throws the difference away and records six status flags in a register. The flags are carry, zero, sign, overflow, parity and adjust. The operands are only inputs, so the compare cannot change them.

A 4-bit condition select picks one of 16 signed or unsigned conditions, each evaluated against the stored flags. A conditional move strobe uses that condition to decide the next destination value. When the condition holds, the source value is written. When it does not, the current destination passes through unchanged. Conditional moves are limited to 16 and 32 bits. A byte-sized move request is rejected and leaves the destination untouched.

The flag register is the only state in the unit. Condition evaluation and the move result are combinational from the stored flags and the current inputs.

Top module: `cmp_cond_unit`

## Requirements
- R1: When `cmp_i` is high and `size_i` is 0 (8 bit), 1 (16 bit) or 2 (32 bit), the flags are recomputed from `op_a_i - op_b_i` at that width and appear on `flags_o` after the next clock edge. A compare with `size_i` = 3 is ignored.
- R2: CF is 1 when the unsigned value of op_a at the width is below that of op_b. ZF is 1 when the difference at the width is zero. SF is the top bit of the difference at the width.
- R3: OF is 1 when the operands' top bits differ and the difference's top bit differs from op_a's top bit (signed overflow of the subtraction).
- R4: PF is 1 when the low byte of the difference contains an even number of ones.
- R5: AF is 1 when `op_a_i[3:0]` is below `op_b_i[3:0]` (borrow from bit 4 into bit 3).
- R6: The `flags_o` layout is bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF. All flags are 0 after reset. Flags hold in every cycle without a valid compare, and a move never alters them.
- R7: `cond_true_o` evaluates `cc_i` against the stored flags using this encoding: 0 OF, 1 !OF, 2 CF, 3 !CF, 4 ZF, 5 !ZF, 6 CF|ZF, 7 !(CF|ZF), 8 SF, 9 !SF, 10 PF, 11 !PF, 12 SF^OF, 13 !(SF^OF), 14 (SF^OF)|ZF, 15 !((SF^OF)|ZF). An odd code is the complement of the even code below it.
- R8: When `mov_i` is high, the size is valid and the condition is true, `dst_next_o` equals `src_i` for size 2. For size 1 it equals `{dst_i[31:16], src_i[15:0]}`.
- R9: When `mov_i` is low or the condition is false, `dst_next_o` equals `dst_i`.
- R10: A move with `size_i` = 0 or 3 is rejected: `reject_o` is 1 and `dst_next_o` equals `dst_i` whatever the condition. `reject_o` is 0 in every other case.
- R11: A move issued in the same cycle as a compare is evaluated on the flags from before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 dword, 3 reserved |
| cmp_i | input | 1 | Compare strobe |
| op_a_i | input | 32 | First compare operand (minuend) |
| op_b_i | input | 32 | Second compare operand (subtrahend) |
| mov_i | input | 1 | Conditional move strobe |
| cc_i | input | 4 | Condition select |
| src_i | input | 32 | Move source value |
| dst_i | input | 32 | Current destination value |
| flags_o | output | 6 | Stored flags {OF,SF,ZF,AF,PF,CF} |
| cond_true_o | output | 1 | Selected condition holds on stored flags |
| reject_o | output | 1 | Move request has an unsupported size |
| dst_next_o | output | 32 | Next destination value |

## Verification
A compare and a conditional move can fall in the same cycle. The stored flags then have to feed the move while the new flags are only being formed. The bench provokes this with a directed pair: the first compare leaves a flag set, and the second compare, issued together with a move on that flag, clears it. The move is judged on the old flags in that cycle, and the new flags are judged one cycle later. Random traffic with both strobes often high at once adds further cases, each compared against a behavioural model that updates its flags only at the clock edge.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CC_W    = 4;
  localparam int unsigned NUM_LANE = 3;  // 8, 16, 32 bit lanes

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } size_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } flags_t;

  localparam int unsigned FLAG_W = $bits(flags_t);
endpackage

// File: rtl/cmpc_flag_calc.sv
module cmpc_flag_calc
  import cmpc_pkg::*;
(
  input  size_e              size_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output flags_t             flags_o
);
  flags_t lane_f [NUM_LANE];

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    localparam int unsigned W = 8 << g;
    logic [W:0]   d;
    logic [W-1:0] r;
    always_comb begin
      d = {1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]};
      r = d[W-1:0];
      lane_f[g].cf_f = d[W];
      lane_f[g].zf_f = (r == '0);
      lane_f[g].sf_f = r[W-1];
      lane_f[g].of_f = (a_i[W-1] ^ b_i[W-1]) & (r[W-1] ^ a_i[W-1]);
      lane_f[g].pf_f = ~^r[7:0];
      lane_f[g].af_f = (a_i[3:0] < b_i[3:0]);
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: flags_o = lane_f[0];
      SZ_WORD: flags_o = lane_f[1];
      default: flags_o = lane_f[2];
    endcase
  end
endmodule

// File: rtl/cmpc_cond_eval.sv
module cmpc_cond_eval
  import cmpc_pkg::*;
(
  input  flags_t          flags_i,
  input  logic [CC_W-1:0] cc_i,
  output logic            hit_o
);
  logic base;
  logic lt;

  always_comb begin
    lt = flags_i.sf_f ^ flags_i.of_f;
    unique case (cc_i[CC_W-1:1])
      3'd0: base = flags_i.of_f;
      3'd1: base = flags_i.cf_f;
      3'd2: base = flags_i.zf_f;
      3'd3: base = flags_i.cf_f | flags_i.zf_f;
      3'd4: base = flags_i.sf_f;
      3'd5: base = flags_i.pf_f;
      3'd6: base = lt;
      default: base = lt | flags_i.zf_f;
    endcase
    hit_o = base ^ cc_i[0];  // odd code negates
  end
endmodule

// File: rtl/cmpc_move_mux.sv
module cmpc_move_mux
  import cmpc_pkg::*;
(
  input  logic              mov_i,
  input  size_e             size_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic              reject_o,
  output logic [DATA_W-1:0] dst_next_o
);
  localparam int unsigned HALF = DATA_W / 2;
  logic size_ok;

  always_comb begin
    size_ok    = (size_i == SZ_WORD) || (size_i == SZ_DWORD);
    reject_o   = mov_i & ~size_ok;
    dst_next_o = dst_i;
    if (mov_i && size_ok && hit_i) begin
      if (size_i == SZ_WORD) dst_next_o = {dst_i[DATA_W-1:HALF], src_i[HALF-1:0]};
      else                   dst_next_o = src_i;
    end
  end
endmodule

// File: rtl/cmp_cond_unit.sv
module cmp_cond_unit
  import cmpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_i,
  input  logic              cmp_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              mov_i,
  input  logic [CC_W-1:0]   cc_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              cond_true_o,
  output logic              reject_o,
  output logic [DATA_W-1:0] dst_next_o
);
  size_e  size;
  flags_t new_f, flags_q;
  logic   hit;

  assign size = size_e'(size_i);

  cmpc_flag_calc u_calc (
    .size_i (size),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .flags_o(new_f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         flags_q <= '0;
    else if (cmp_i && size != SZ_RSVD)   flags_q <= new_f;
  end

  cmpc_cond_eval u_cond (
    .flags_i(flags_q),
    .cc_i   (cc_i),
    .hit_o  (hit)
  );

  cmpc_move_mux u_mov (
    .mov_i     (mov_i),
    .size_i    (size),
    .hit_i     (hit),
    .src_i     (src_i),
    .dst_i     (dst_i),
    .reject_o  (reject_o),
    .dst_next_o(dst_next_o)
  );

  assign flags_o     = flags_q;
  assign cond_true_o = hit;
endmodule

// File: rtl/cmp_cond_unit_chk.sv
module cmp_cond_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  size_i,
  input logic        cmp_i,
  input logic [31:0] op_a_i,
  input logic [31:0] op_b_i,
  input logic        mov_i,
  input logic [31:0] src_i,
  input logic [31:0] dst_i,
  input logic [5:0]  flags_o,
  input logic        cond_true_o,
  input logic        reject_o,
  input logic [31:0] dst_next_o
);
  a_r6_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_i || size_i == 2'd3) |=> $stable(flags_o));

  a_r9_false_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mov_i || !cond_true_o) |-> dst_next_o == dst_i);

  a_r10_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mov_i && (size_i == 2'd0 || size_i == 2'd3)) |-> (reject_o && dst_next_o == dst_i));

  a_r8_move_dword: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mov_i && size_i == 2'd2 && cond_true_o) |-> dst_next_o == src_i);

  a_r2_equal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && size_i == 2'd2 && op_a_i == op_b_i) |=> (flags_o[3] && !flags_o[0]));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && size_i == 2'd2 && op_a_i[31] == op_b_i[31]) |=> !flags_o[5]);
endmodule

bind cmp_cond_unit cmp_cond_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .size_i(size_i), .cmp_i(cmp_i),
  .op_a_i(op_a_i), .op_b_i(op_b_i), .mov_i(mov_i), .src_i(src_i),
  .dst_i(dst_i), .flags_o(flags_o), .cond_true_o(cond_true_o),
  .reject_o(reject_o), .dst_next_o(dst_next_o)
);

// File: tb/sim_cmp_cond_unit.sv
`timescale 1ns/1ps
module sim_cmp_cond_unit;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [1:0]  size_i = 0;
  logic        cmp_i = 0;
  logic [31:0] op_a_i = 0, op_b_i = 0;
  logic        mov_i = 0;
  logic [3:0]  cc_i = 0;
  logic [31:0] src_i = 0, dst_i = 0;
  logic [5:0]  flags_o;
  logic        cond_true_o, reject_o;
  logic [31:0] dst_next_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string req = "R6";
  // model flags: [0]cf [1]pf [2]af [3]zf [4]sf [5]of
  logic [5:0] m_flags = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  cmp_cond_unit u0 (.*);

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_flags(input int sz, input logic [31:0] a, input logic [31:0] b);
    int w; longint mask, ua, ub, d, res, sa, sb, sd, lo, hi;
    logic [5:0] f;
    w = 8 << sz;
    mask = (64'd1 << w) - 1;
    ua = a & mask; ub = b & mask;
    sa = (ua >= (64'd1 << (w-1))) ? ua - (64'd1 << w) : ua;
    sb = (ub >= (64'd1 << (w-1))) ? ub - (64'd1 << w) : ub;
    d = ua - ub; res = d & mask; sd = sa - sb;
    lo = -(64'd1 << (w-1)); hi = (64'd1 << (w-1)) - 1;
    f[0] = ua < ub;
    f[1] = ($countones(res[7:0]) % 2) == 0;
    f[2] = (a & 15) < (b & 15);
    f[3] = res == 0;
    f[4] = res[w-1];
    f[5] = (sd < lo) || (sd > hi);
    return f;
  endfunction

  function automatic logic ref_cond(input logic [5:0] f, input int cc);
    logic cf, pf, zf, sf, of;
    {of, sf, zf, pf, cf} = {f[5], f[4], f[3], f[1], f[0]};
    case (cc)
      0: return of;            1: return !of;
      2: return cf;            3: return !cf;
      4: return zf;            5: return !zf;
      6: return cf || zf;      7: return !cf && !zf;
      8: return sf;            9: return !sf;
      10: return pf;           11: return !pf;
      12: return sf != of;     13: return sf == of;
      14: return (sf != of) || zf;
      default: return (sf == of) && !zf;
    endcase
  endfunction

  task automatic step(input int sz, input bit c, input logic [31:0] a, input logic [31:0] b,
                      input bit m, input int cc, input logic [31:0] s, input logic [31:0] d);
    logic ok, rej; logic [31:0] exp_d;
    size_i = sz[1:0]; cmp_i = c; op_a_i = a; op_b_i = b;
    mov_i = m; cc_i = cc[3:0]; src_i = s; dst_i = d;
    @(negedge clk_i);
    ok = ref_cond(m_flags, cc);
    rej = m && (sz == 0 || sz == 3);
    exp_d = d;
    if (m && !rej && ok) exp_d = (sz == 1) ? {d[31:16], s[15:0]} : s;
    chk(req, "flags", flags_o, m_flags);
    chk(req, "cond", cond_true_o, ok);
    chk(req, "reject", reject_o, rej);
    chk(req, "dst_next", dst_next_o, exp_d);
    @(posedge clk_i);
    if (c && sz != 3) m_flags = ref_flags(sz, a, b);
    #1;
  endtask

  task automatic cmpx(input int sz, input logic [31:0] a, input logic [31:0] b);
    step(sz, 1, a, b, 0, 0, 0, 0);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    req = "R6"; chk(req, "reset flags", flags_o, 6'd0);
    rst_ni = 1;
    @(posedge clk_i); #1;
    // R1 R2: equal, below, widths
    req = "R2"; cmpx(2, 32'd5, 32'd5);
    req = "R2"; cmpx(2, 32'd3, 32'd5);
    req = "R1"; cmpx(1, 32'hABCD_0003, 32'h1234_0005);
    req = "R1"; cmpx(0, 32'h0000_1280, 32'h0000_3480);
    // R3 overflow at each width
    req = "R3"; cmpx(2, 32'h8000_0000, 32'd1);
    req = "R3"; cmpx(1, 32'h0000_8000, 32'd1);
    req = "R3"; cmpx(0, 32'h0000_007F, 32'h0000_00FF);
    // R4 parity, R5 adjust
    req = "R4"; cmpx(2, 32'h0000_0003, 32'h0);
    req = "R4"; cmpx(2, 32'h0000_0007, 32'h0);
    req = "R5"; cmpx(0, 32'h10, 32'h01);
    req = "R5"; cmpx(2, 32'h1F, 32'h0E);
    // R1 reserved compare ignored, R6 hold
    req = "R1"; step(3, 1, 32'd1, 32'd2, 0, 0, 0, 0);
    req = "R6"; step(0, 0, 32'd9, 32'd1, 1, 4, 32'h11, 32'h22);
    // R7 all codes against a couple of flag states; R8/R9 moves
    cmpx(2, 32'hFFFF_FFFE, 32'd3);
    for (int k = 0; k < 16; k++) begin req = "R7"; step(2, 0, 0, 0, 1, k, 32'hDEAD_BEEF, 32'h0123_4567); end
    cmpx(2, 32'd7, 32'd7);
    for (int k = 0; k < 16; k++) begin req = "R8"; step(1, 0, 0, 0, 1, k, 32'hDEAD_BEEF, 32'h0123_4567); end
    req = "R9"; step(2, 0, 0, 0, 0, 4, 32'hAAAA_AAAA, 32'h5555_5555);
    // R10 rejected sizes
    req = "R10"; step(0, 0, 0, 0, 1, 4, 32'hAAAA_AAAA, 32'h5555_5555);
    req = "R10"; step(3, 0, 0, 0, 1, 5, 32'hAAAA_AAAA, 32'h5555_5555);
    // R11 compare clears ZF while move on ZF in same cycle uses old ZF
    cmpx(2, 32'd4, 32'd4);
    req = "R11"; step(2, 1, 32'd9, 32'd4, 1, 4, 32'hCAFE_0000, 32'h0000_BEEF);
    req = "R11"; step(2, 0, 0, 0, 1, 4, 32'hCAFE_0000, 32'h0000_BEEF);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      req = "R7";
      step($urandom_range(3), $urandom_range(1), $urandom, ($urandom_range(3) == 0) ? 32'h0 : $urandom,
           $urandom_range(1), $urandom_range(15), $urandom, $urandom);
    end
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule